// File: doc/BRIEF.md
# Programmable Memory Bank Address Decoder

This block maps a 32-bit bus address onto a set of memory regions. Two regions are fixed at the top of the map: a 1 MB on-chip peripheral window at 0xFFF0_0000 to 0xFFFF_FFFF and a 1 MB on-chip RAM window at 0xFFE0_0000 to 0xFFEF_FFFF. The remaining regions are `NBANKS` programmable banks. Each bank has a 13-bit base pointer in 256 KB steps and a power-of-two size code. Both are loaded through a one-cycle register write port.

The decode from address to selects, offset, cacheable attribute and abort is purely combinational. Address bit 31 picks the alias: the lower half of the map is cacheable and the upper half is not. Programmable banks are matched on bits [30:18], so either alias reaches the same bank. An access that hits nothing raises abort. Software must keep banks disjoint. If two banks overlap anyway, the lowest-numbered bank wins and a sticky error flag records the event.

Top module: `mbank_decode`

## Requirements
- R1: An address with bits [31:20] equal to 0xFFF asserts `periph_sel`, and `offset` equals address bits [19:0].
- R2: An address with bits [31:20] equal to 0xFFE asserts `ram_sel`, and `offset` equals address bits [19:0].
- R3: A bank with base pointer P starts at byte P·2^18 within address bits [30:0], whatever the value of bit 31. On a hit, `offset` equals address[30:0] minus that start, and the bank's bit in `bank_sel` is set.
- R4: A bank's 4-bit size code works as follows. Code 0 disables the bank. Code n ≥ 1 covers 256 KB·2^(n-1) bytes from the bank start. The first byte past that span does not hit the bank.
- R5: Banks whose bit is set in `IO_MASK` are I/O banks, and their stored size code is clamped to 5 (4 MB). All other banks are SDRAM banks, clamped to 9 (64 MB).
- R6: When `addr_valid` is high and no window or bank matches, `abort` is high. When `addr_valid` is low, `abort` is low. Whenever nothing matches, `periph_sel`, `ram_sel` and `bank_sel` are all zero and `offset` is zero.
- R7: `cacheable` equals the inverse of address bit 31.
- R8: The fixed windows take priority: when a fixed window matches, `bank_sel` is zero even if a bank also covers the address.
- R9: If several banks match and no fixed window does, only the lowest-numbered bank is selected. `overlap_err` is then set at the next clock edge if `addr_valid` is high, and it stays set until reset.
- R10: After reset every bank is disabled and `overlap_err` is low. A configuration write takes effect in the decode from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a bank configuration |
| cfg_idx | input | IDX_W | Bank number being written |
| cfg_base | input | 13 | Base pointer, 256 KB units |
| cfg_size | input | 4 | Size code (0 = disabled) |
| addr_valid | input | 1 | Address qualifier for abort and overlap detection |
| addr | input | 32 | Bus address |
| periph_sel | output | 1 | Peripheral window select |
| ram_sel | output | 1 | On-chip RAM window select |
| bank_sel | output | NBANKS | One-hot programmable bank select |
| cacheable | output | 1 | Cacheable attribute |
| offset | output | 32 | Byte offset within the selected region |
| abort | output | 1 | Unmapped access |
| overlap_err | output | 1 | Sticky multiple-bank-hit flag |

## Verification
A corrupted stored base or size code shows up on the very next decode of an address near that bank's edges. The symptom is a wrong `bank_sel`, a shifted `offset`, or a spurious `abort`, so the bench probes the first and last byte of every bank and the byte just past it. A clamp that fails to apply is visible only past the clamped span, so those addresses are probed directly. A broken overlap flag appears at the port one edge after the offending access, and its stickiness is checked after the overlap has been removed.

// File: rtl/mbank_pkg.sv
package mbank_pkg;

    localparam int PTR_W      = 13;
    localparam int SZ_W       = 4;
    localparam int UNIT_SHIFT = 18;
    localparam logic [SZ_W-1:0] IO_MAX_CODE = 4'd5;
    localparam logic [SZ_W-1:0] SD_MAX_CODE = 4'd9;
    localparam logic [11:0] PERIPH_TAG = 12'hFFF;
    localparam logic [11:0] RAM_TAG    = 12'hFFE;

    typedef struct packed {
        logic [PTR_W-1:0] base;
        logic [SZ_W-1:0]  size;
    } bank_cfg_t;

    typedef enum logic [1:0] {
        HIT_NONE   = 2'd0,
        HIT_PERIPH = 2'd1,
        HIT_RAM    = 2'd2,
        HIT_BANK   = 2'd3
    } hit_kind_e;

    function automatic logic [SZ_W-1:0] clamp_code(input logic [SZ_W-1:0] c, input logic is_io);
        logic [SZ_W-1:0] lim;
        lim = is_io ? IO_MAX_CODE : SD_MAX_CODE;
        return (c > lim) ? lim : c;
    endfunction

    function automatic logic [PTR_W:0] span_units(input logic [SZ_W-1:0] c);
        if (c == '0) return '0;
        return (PTR_W+1)'(1) << (c - 1'b1);
    endfunction

endpackage

// File: rtl/mbank_regs.sv
module mbank_regs
    import mbank_pkg::*;
#(
    parameter int NBANKS = 4,
    parameter logic [NBANKS-1:0] IO_MASK = '0,
    localparam int IDX_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [IDX_W-1:0]        cfg_idx,
    input  logic [PTR_W-1:0]        cfg_base,
    input  logic [SZ_W-1:0]         cfg_size,
    output bank_cfg_t [NBANKS-1:0]  cfg_q
);

    for (genvar i = 0; i < NBANKS; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (cfg_we && cfg_idx == IDX_W'(i)) begin
                cfg_q[i].base <= cfg_base;
                cfg_q[i].size <= clamp_code(cfg_size, IO_MASK[i]);
            end
        end

        // R5: stored code never exceeds the bank type's limit
        a_r5_clamped: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && cfg_idx == IDX_W'(i)) |=>
                (cfg_q[i].size <= (IO_MASK[i] ? IO_MAX_CODE : SD_MAX_CODE)));
    end

    // R10: configuration is cleared by reset
    a_r10_reset_off: assert property (@(posedge clk)
        $past(rst) |-> (cfg_q[0].size == '0));

endmodule

// File: rtl/mbank_match.sv
module mbank_match
    import mbank_pkg::*;
(
    input  bank_cfg_t    cfg,
    input  logic [30:0]  addr_lo,
    output logic         hit,
    output logic [30:0]  off
);

    logic [PTR_W:0] diff;

    always_comb begin
        diff = {1'b0, addr_lo[30:UNIT_SHIFT]} - {1'b0, cfg.base};
        hit  = (cfg.size != '0) && !diff[PTR_W] && (diff < span_units(cfg.size));
        off  = {diff[PTR_W-1:0], addr_lo[UNIT_SHIFT-1:0]};
    end

endmodule

// File: rtl/mbank_decode.sv
module mbank_decode
    import mbank_pkg::*;
#(
    parameter int NBANKS = 4,
    parameter logic [NBANKS-1:0] IO_MASK = 4'b0011,
    localparam int IDX_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [12:0]       cfg_base,
    input  logic [3:0]        cfg_size,
    input  logic              addr_valid,
    input  logic [31:0]       addr,
    output logic              periph_sel,
    output logic              ram_sel,
    output logic [NBANKS-1:0] bank_sel,
    output logic              cacheable,
    output logic [31:0]       offset,
    output logic              abort,
    output logic              overlap_err
);

    bank_cfg_t [NBANKS-1:0] cfg_q;
    logic [NBANKS-1:0]      hits;
    logic [NBANKS-1:0]      first;
    logic [30:0]            offs [NBANKS];
    hit_kind_e              kind;
    logic [30:0]            bank_off;
    logic                   multi;

    mbank_regs #(.NBANKS(NBANKS), .IO_MASK(IO_MASK)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_base (cfg_base),
        .cfg_size (cfg_size),
        .cfg_q    (cfg_q)
    );

    for (genvar i = 0; i < NBANKS; i++) begin : g_match
        mbank_match u_m (
            .cfg     (cfg_q[i]),
            .addr_lo (addr[30:0]),
            .hit     (hits[i]),
            .off     (offs[i])
        );
    end

    always_comb begin
        first    = hits & (~hits + 1'b1);
        multi    = (hits & (hits - 1'b1)) != '0;
        bank_off = '0;
        for (int i = 0; i < NBANKS; i++) begin
            if (first[i]) bank_off = offs[i];
        end

        if (addr[31:20] == PERIPH_TAG)   kind = HIT_PERIPH;
        else if (addr[31:20] == RAM_TAG) kind = HIT_RAM;
        else if (hits != '0)             kind = HIT_BANK;
        else                             kind = HIT_NONE;

        periph_sel = (kind == HIT_PERIPH);
        ram_sel    = (kind == HIT_RAM);
        bank_sel   = (kind == HIT_BANK) ? first : '0;
        abort      = addr_valid && (kind == HIT_NONE);
        cacheable  = ~addr[31];
        case (kind)
            HIT_PERIPH, HIT_RAM: offset = {12'd0, addr[19:0]};
            HIT_BANK:            offset = {1'b0, bank_off};
            default:             offset = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                                         overlap_err <= 1'b0;
        else if (addr_valid && kind == HIT_BANK && multi) overlap_err <= 1'b1;
    end

    // R1 / R8: peripheral window wins outright
    a_r1_periph_wins: assert property (@(posedge clk) disable iff (rst)
        (addr[31:20] == 12'hFFF) |-> (periph_sel && !ram_sel && bank_sel == '0 && !abort));

    // R8: RAM window suppresses bank selects
    a_r8_ram_wins: assert property (@(posedge clk) disable iff (rst)
        (addr[31:20] == 12'hFFE) |-> (ram_sel && bank_sel == '0));

    // R6: an abort carries no select
    a_r6_abort_quiet: assert property (@(posedge clk) disable iff (rst)
        abort |-> (!periph_sel && !ram_sel && bank_sel == '0 && offset == '0));

    // R9: at most one bank selected
    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({periph_sel, ram_sel, bank_sel}));

    // R9: overlap flag is sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        overlap_err |=> overlap_err);

endmodule

// File: tb/sim_mbank_decode.sv
module sim_mbank_decode;

    localparam int NB = 4;
    localparam logic [NB-1:0] IOM = 4'b0011;

    typedef struct {
        string       req;
        logic [31:0] a;
        logic        per;
        logic        ram;
        logic [NB-1:0] sel;
        logic        cach;
        logic [31:0] off;
        logic        abt;
    } exp_t;

    logic clk = 0, rst = 1;
    logic cfg_we = 0;
    logic [1:0] cfg_idx = 0;
    logic [12:0] cfg_base = 0;
    logic [3:0] cfg_size = 0;
    logic addr_valid = 0;
    logic [31:0] addr = 0;
    logic periph_sel, ram_sel, cacheable, abort, overlap_err;
    logic [NB-1:0] bank_sel;
    logic [31:0] offset;

    int total = 0, bad = 0;
    bit done = 0;
    exp_t q[$];
    logic [12:0] sh_base [NB];
    logic [3:0]  sh_size [NB];

    always #4 clk = ~clk;

    mbank_decode #(.NBANKS(NB), .IO_MASK(IOM)) u0 (.*);

    function automatic exp_t model(string req, logic [31:0] a, logic v);
        exp_t e;
        logic [31:0] lo, st, sp;
        e.req = req; e.a = a; e.per = 0; e.ram = 0; e.sel = '0;
        e.cach = !a[31]; e.off = 0; e.abt = 0;
        lo = {1'b0, a[30:0]};
        if (a[31:20] == 12'hFFF) begin e.per = 1; e.off = {12'd0, a[19:0]}; end
        else if (a[31:20] == 12'hFFE) begin e.ram = 1; e.off = {12'd0, a[19:0]}; end
        else begin
            for (int i = NB - 1; i >= 0; i--) begin
                if (sh_size[i] != 0) begin
                    st = {1'b0, sh_base[i], 18'd0};
                    sp = 32'd262144 << (sh_size[i] - 1);
                    if (lo >= st && lo < st + sp) begin
                        e.sel = '0; e.sel[i] = 1'b1; e.off = lo - st;
                    end
                end
            end
            if (e.sel == '0) e.abt = v;
        end
        return e;
    endfunction

    task automatic wr(int idx, logic [12:0] b, logic [3:0] s);
        logic [3:0] lim;
        @(negedge clk);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_base = b; cfg_size = s;
        @(negedge clk);
        cfg_we = 0;
        lim = IOM[idx] ? 4'd5 : 4'd9;
        sh_base[idx] = b;
        sh_size[idx] = (s > lim) ? lim : s;
    endtask

    task automatic drive(string req, logic [31:0] a, logic v = 1);
        @(negedge clk);
        addr = a; addr_valid = v;
        q.push_back(model(req, a, v));
    endtask

    task automatic chk_ovl(string req, logic expv);
        @(negedge clk); #2;
        total++;
        if (overlap_err !== expv) begin
            bad++;
            $display("FAIL %s overlap_err got=%0b exp=%0b", req, overlap_err, expv);
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk); #2;
            if (q.size() != 0) begin
                e = q.pop_front();
                total++;
                if ({periph_sel, ram_sel, bank_sel, cacheable, offset, abort} !==
                    {e.per, e.ram, e.sel, e.cach, e.off, e.abt}) begin
                    bad++;
                    $display("FAIL %s addr=%h got per=%0b ram=%0b sel=%b c=%0b off=%h abt=%0b exp per=%0b ram=%0b sel=%b c=%0b off=%h abt=%0b",
                        e.req, e.a, periph_sel, ram_sel, bank_sel, cacheable, offset, abort,
                        e.per, e.ram, e.sel, e.cach, e.off, e.abt);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < NB; i++) begin sh_base[i] = 0; sh_size[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        // R10: reset leaves every bank disabled, flag low
        chk_ovl("R10", 0);
        drive("R10", 32'h0000_0000);
        drive("R6", 32'h0040_0000, 0);
        // R10: write visible right after the capturing edge
        wr(0, 13'h010, 4'd3);
        drive("R10", 32'h0040_0000);
        // R3 / R4: first, last, one-past
        drive("R3", 32'h0040_1234);
        drive("R4", 32'h004F_FFFF);
        drive("R4", 32'h0050_0000);
        // R3 / R7: non-cacheable alias hits same bank
        drive("R7", 32'h8040_0010);
        // R5: clamps
        wr(1, 13'h040, 4'd7);
        drive("R5", 32'h013F_FFFC);
        drive("R5", 32'h0140_0000);
        wr(2, 13'h100, 4'd15);
        drive("R5", 32'h0400_0000);
        drive("R5", 32'h07FF_FFFF);
        drive("R5", 32'h0800_0000);
        // R1 / R2 / R6 fixed windows and gap
        drive("R1", 32'hFFF0_0000);
        drive("R1", 32'hFFFF_FFFC);
        drive("R2", 32'hFFE0_0040);
        drive("R6", 32'hFFDF_FFFC);
        drive("R6", 32'h7000_0000);
        // R8: bank aliasing under the RAM window
        wr(3, 13'h1FF8, 4'd4);
        drive("R8", 32'hFFE0_0010);
        drive("R8", 32'h7FE0_0010);
        chk_ovl("R8", 0);
        // R9: overlap, lowest wins, sticky
        wr(3, 13'h011, 4'd1);
        drive("R9", 32'h0044_0000);
        chk_ovl("R9", 1);
        wr(3, 13'h1000, 4'd1);
        drive("R9", 32'h4000_0000);
        chk_ovl("R9", 1);
        // R4: disabling a bank
        wr(0, 13'h010, 4'd0);
        drive("R4", 32'h0040_0000);
        // R10: reset clears flag and banks
        @(negedge clk) rst = 1;
        @(negedge clk) rst = 0;
        for (int i = 0; i < NB; i++) sh_size[i] = 0;
        chk_ovl("R10", 0);
        drive("R10", 32'h0100_0000);
        repeat (4) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule